// File: doc/BRIEF.md
# Level/Edge Interrupt Source State Array

This block holds the interrupt state of a bank of `NUM_SRC` sources. Each source has a two-bit pending/queued state, an asserted flag and a kind bit. The kind bit is 0 for an edge (message-style) source and 1 for a level source. The two-bit state encodes four named states: IDLE (2'b00, ready to fire), OFF (2'b01, masked), PENDING (2'b10, forwarded and waiting for end-of-interrupt) and QUEUED (2'b11, pending with a second event held).

A trigger moves IDLE to PENDING and forwards the event. A trigger moves PENDING to QUEUED. QUEUED and OFF hold on a trigger. An end-of-interrupt (EOI) moves PENDING to IDLE. An EOI moves QUEUED back to PENDING and forwards the held event. An EOI leaves IDLE and OFF unchanged.

Level sources do not use QUEUED to remember a second event. They keep the asserted flag instead. At EOI the level source is checked again: if it is still asserted and has reached IDLE, it fires again.

Each input line change, and each command on the command port, is one event, and only one event is taken per cycle. Line changes always go first. When several lines have changed, the lowest index is taken first. The command port accepts four operations:
- trigger
- EOI
- write of the two-bit state
- write of the kind bit

A separate combinational read port shows the kind bit, the asserted flag and the two-bit state of any source. A forwarded event appears as a one-cycle `notify` pulse together with the source index. The block sits between the interrupt lines and a routing stage.

Top module: `isrc_state_array`

## Requirements
- R1: Reset sets every source's state to OFF (2'b01) and clears every asserted flag and `bad_idx_err`. Reset leaves the kind bits unchanged.
- R2: A trigger command on a source, or a rising line on an edge source, gives the following transitions: IDLE goes to PENDING and notifies; PENDING goes to QUEUED; QUEUED stays QUEUED; OFF stays OFF. Only the IDLE case notifies.
- R3: An EOI command on an edge source gives the following transitions: PENDING goes to IDLE; QUEUED goes to PENDING and notifies; IDLE and OFF are unchanged. Only the QUEUED case notifies.
- R4: A rising line on a level source sets its asserted flag and leaves its state unchanged. It notifies only if the state is IDLE. A falling line on a level source clears the flag and does not notify.
- R5: A falling line on an edge source changes no state and does not notify.
- R6: An EOI on a level source first applies the R3 state update. It then notifies only if the asserted flag is set and the new state is IDLE.
- R7: When a trigger command leaves a level source in QUEUED, `guest_err` pulses for one cycle with that index in `guest_err_idx`.
- R8: `rd_data` is {kind, asserted, P, Q} in bits 3..0 for source `rd_idx`, where P is the upper state bit and Q the lower. An `rd_idx` of `NUM_SRC` or more reads 0.
- R9: `cmd_op` 2'b10 writes `cmd_wdata` into the state. `cmd_op` 2'b11 writes `cmd_wdata[0]` into the kind bit (1 = level). 2'b00 is trigger and 2'b01 is EOI.
- R10: One event is processed per cycle. `cmd_ready` is low while any line differs from its last processed value. Changed lines are taken lowest index first, one per cycle, and a held command is accepted once all line changes are taken.
- R11: A command whose index is `NUM_SRC` or more changes no source and gives no notify. It sets `bad_idx_err`, which stays set until reset.
- R12: `notify` and `notify_idx` are valid for exactly one cycle after the clock edge that takes the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_SRC | Interrupt input lines, one per source |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 trigger, 01 EOI, 10 write state, 11 write kind |
| cmd_idx | input | IDX_W | Command source index |
| cmd_wdata | input | 2 | Write data for the state or kind writes |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| rd_idx | input | IDX_W | Read port source index |
| rd_data | output | 4 | {kind, asserted, P, Q} of `rd_idx` |
| notify | output | 1 | One-cycle pulse: event forwarded |
| notify_idx | output | IDX_W | Source of the forwarded event |
| guest_err | output | 1 | One-cycle pulse: level source queued by a trigger |
| guest_err_idx | output | IDX_W | Source of the guest error |
| bad_idx_err | output | 1 | Sticky out-of-range command flag |

## Verification
A wrong state-bit update cannot be seen at the time it happens. It first shows as a missing or extra `notify` on a later trigger or EOI to that source, so each transition is checked both through the read port in the next cycle and through the notify that follows it. A stale asserted flag shows only at the next EOI on that level source, as a wrong re-notify, so level EOIs are swept with the flag both set and clear. An arbitration fault shows within one or two cycles as a wrong `notify_idx` order or as a command taken while `cmd_ready` should be low.

// File: rtl/isrc_pkg.sv
package isrc_pkg;

    typedef enum logic [1:0] {
        OP_TRIG    = 2'b00,
        OP_EOI     = 2'b01,
        OP_WR_PQ   = 2'b10,
        OP_WR_KIND = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_LINE,
        EV_CMD,
        EV_BADIDX
    } evt_kind_e;

    localparam logic [1:0] PQ_IDLE   = 2'b00;
    localparam logic [1:0] PQ_OFF    = 2'b01;
    localparam logic [1:0] PQ_PEND   = 2'b10;
    localparam logic [1:0] PQ_QUEUED = 2'b11;

    typedef struct packed {
        logic [1:0] pq;
        logic       fire;
    } pq_step_t;

    function automatic pq_step_t pq_trigger(input logic [1:0] cur);
        pq_step_t s;
        unique case (cur)
            PQ_IDLE:   begin s.pq = PQ_PEND;   s.fire = 1'b1; end
            PQ_PEND:   begin s.pq = PQ_QUEUED; s.fire = 1'b0; end
            PQ_QUEUED: begin s.pq = PQ_QUEUED; s.fire = 1'b0; end
            PQ_OFF:    begin s.pq = PQ_OFF;    s.fire = 1'b0; end
        endcase
        return s;
    endfunction

    function automatic pq_step_t pq_eoi(input logic [1:0] cur);
        pq_step_t s;
        unique case (cur)
            PQ_PEND:   begin s.pq = PQ_IDLE;   s.fire = 1'b0; end
            PQ_QUEUED: begin s.pq = PQ_PEND;   s.fire = 1'b1; end
            PQ_IDLE:   begin s.pq = PQ_IDLE;   s.fire = 1'b0; end
            PQ_OFF:    begin s.pq = PQ_OFF;    s.fire = 1'b0; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/isrc_line_arb.sv
module isrc_line_arb #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/isrc_rules.sv
module isrc_rules
    import isrc_pkg::*;
(
    input  evt_kind_e  kind,
    input  cmd_op_e    op,
    input  logic       is_level,
    input  logic       asrt,
    input  logic [1:0] pq,
    input  logic       line_val,
    input  logic [1:0] wdata,
    output logic [1:0] pq_nxt,
    output logic       asrt_nxt,
    output logic       notify,
    output logic       guest_err
);
    pq_step_t step;

    always_comb begin
        pq_nxt    = pq;
        asrt_nxt  = asrt;
        notify    = 1'b0;
        guest_err = 1'b0;
        step      = '0;
        unique case (kind)
            EV_LINE: begin
                if (is_level) begin
                    asrt_nxt = line_val;
                    notify   = line_val && (pq == PQ_IDLE);
                end else if (line_val) begin
                    step   = pq_trigger(pq);
                    pq_nxt = step.pq;
                    notify = step.fire;
                end
            end
            EV_CMD: begin
                unique case (op)
                    OP_TRIG: begin
                        step      = pq_trigger(pq);
                        pq_nxt    = step.pq;
                        notify    = step.fire;
                        guest_err = is_level && (step.pq == PQ_QUEUED);
                    end
                    OP_EOI: begin
                        step   = pq_eoi(pq);
                        pq_nxt = step.pq;
                        notify = is_level ? (asrt && (step.pq == PQ_IDLE))
                                          : step.fire;
                    end
                    OP_WR_PQ: begin
                        pq_nxt = wdata;
                    end
                    OP_WR_KIND: begin
                        pq_nxt = pq;
                    end
                endcase
            end
            EV_NONE, EV_BADIDX: begin
                pq_nxt = pq;
            end
        endcase
    end
endmodule

// File: rtl/isrc_state_array.sv
module isrc_state_array
    import isrc_pkg::*;
#(
    parameter int NUM_SRC = 6,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [1:0]         cmd_wdata,
    output logic               cmd_ready,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [3:0]         rd_data,
    output logic               notify,
    output logic [IDX_W-1:0]   notify_idx,
    output logic               guest_err,
    output logic [IDX_W-1:0]   guest_err_idx,
    output logic               bad_idx_err
);
    localparam logic [IDX_W:0] SRC_LIM = (IDX_W + 1)'(NUM_SRC);

    logic [NUM_SRC-1:0][1:0] pq_q;
    logic [NUM_SRC-1:0]      asrt_q;
    logic [NUM_SRC-1:0]      kind_q;
    logic [NUM_SRC-1:0]      seen_q;

    logic             line_hit;
    logic [IDX_W-1:0] line_idx;
    evt_kind_e        evt_kind;
    logic [IDX_W-1:0] sel_idx;
    logic             evt_active;
    cmd_op_e          op;
    logic [1:0]       sel_pq;
    logic             sel_asrt;
    logic             sel_kind;
    logic             sel_line;
    logic [1:0]       rule_pq;
    logic             rule_asrt;
    logic             rule_notify;
    logic             rule_gerr;

    assign op = cmd_op_e'(cmd_op);

    isrc_line_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .req (line_in ^ seen_q),
        .hit (line_hit),
        .idx (line_idx)
    );

    // event selection: line changes before commands
    always_comb begin
        evt_kind = EV_NONE;
        sel_idx  = '0;
        if (line_hit) begin
            evt_kind = EV_LINE;
            sel_idx  = line_idx;
        end else if (cmd_valid) begin
            if ({1'b0, cmd_idx} < SRC_LIM) begin
                evt_kind = EV_CMD;
                sel_idx  = cmd_idx;
            end else begin
                evt_kind = EV_BADIDX;
            end
        end
    end

    assign cmd_ready  = !line_hit;
    assign evt_active = (evt_kind == EV_LINE) || (evt_kind == EV_CMD);

    always_comb begin
        sel_pq   = PQ_OFF;
        sel_asrt = 1'b0;
        sel_kind = 1'b0;
        sel_line = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_pq   = pq_q[i];
                sel_asrt = asrt_q[i];
                sel_kind = kind_q[i];
                sel_line = line_in[i];
            end
        end
    end

    isrc_rules u_rules (
        .kind      (evt_kind),
        .op        (op),
        .is_level  (sel_kind),
        .asrt      (sel_asrt),
        .pq        (sel_pq),
        .line_val  (sel_line),
        .wdata     (cmd_wdata),
        .pq_nxt    (rule_pq),
        .asrt_nxt  (rule_asrt),
        .notify    (rule_notify),
        .guest_err (rule_gerr)
    );

    // per-source state registers
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic       hit_g;
        logic [1:0] pq_r;
        logic       asrt_r;
        logic       seen_r;
        logic       kind_r;

        assign hit_g = evt_active && (sel_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pq_r   <= PQ_OFF;
                asrt_r <= 1'b0;
                seen_r <= 1'b0;
            end else if (hit_g) begin
                pq_r   <= rule_pq;
                asrt_r <= rule_asrt;
                if (evt_kind == EV_LINE) begin
                    seen_r <= sel_line;
                end
            end
        end

        // kind map survives reset
        always_ff @(posedge clk) begin
            if (hit_g && (evt_kind == EV_CMD) && (op == OP_WR_KIND)) begin
                kind_r <= cmd_wdata[0];
            end
        end

        assign pq_q[g]   = pq_r;
        assign asrt_q[g] = asrt_r;
        assign seen_q[g] = seen_r;
        assign kind_q[g] = kind_r;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            notify        <= 1'b0;
            notify_idx    <= '0;
            guest_err     <= 1'b0;
            guest_err_idx <= '0;
            bad_idx_err   <= 1'b0;
        end else begin
            notify        <= evt_active && rule_notify;
            notify_idx    <= sel_idx;
            guest_err     <= evt_active && rule_gerr;
            guest_err_idx <= sel_idx;
            if (evt_kind == EV_BADIDX) begin
                bad_idx_err <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = {kind_q[i], asrt_q[i], pq_q[i]};
            end
        end
    end
endmodule

module isrc_state_array_chk #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    notify,
    input logic [IDX_W-1:0]        notify_idx,
    input logic                    guest_err,
    input logic [IDX_W-1:0]        guest_err_idx,
    input logic                    bad_idx_err,
    input logic [NUM_SRC-1:0][1:0] pq_q,
    input logic [NUM_SRC-1:0]      asrt_q,
    input logic [NUM_SRC-1:0]      kind_q
);
    localparam logic [IDX_W:0] LIM = (IDX_W + 1)'(NUM_SRC);

    // R12
    notify_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> ({1'b0, notify_idx} < LIM));

    // R2
    edge_notify_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (notify && !kind_q[notify_idx]) |-> (pq_q[notify_idx] == 2'b10));

    // R6
    level_notify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (notify && kind_q[notify_idx]) |-> (asrt_q[notify_idx] || pq_q[notify_idx] == 2'b10));

    // R7
    guest_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guest_err |-> (pq_q[guest_err_idx] == 2'b11 && kind_q[guest_err_idx]));

    // R11
    bad_idx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx_err |=> bad_idx_err);
endmodule

bind isrc_state_array isrc_state_array_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .notify        (notify),
    .notify_idx    (notify_idx),
    .guest_err     (guest_err),
    .guest_err_idx (guest_err_idx),
    .bad_idx_err   (bad_idx_err),
    .pq_q          (pq_q),
    .asrt_q        (asrt_q),
    .kind_q        (kind_q)
);

// File: tb/isrc_state_array_bench.sv
module isrc_state_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [IW-1:0] cmd_idx = '0;
    logic [1:0]    cmd_wdata = 2'b00;
    logic          cmd_ready;
    logic [IW-1:0] rd_idx = '0;
    logic [3:0]    rd_data;
    logic          notify;
    logic [IW-1:0] notify_idx;
    logic          guest_err;
    logic [IW-1:0] guest_err_idx;
    logic          bad_idx_err;

    int n_chk = 0;
    int n_err = 0;
    logic          g_ntf;
    logic [IW-1:0] g_nidx;
    logic          g_gerr;
    logic [IW-1:0] g_gidx;

    always #(CLK_PERIOD/2) clk = ~clk;

    isrc_state_array #(.NUM_SRC(N)) u_isrc_state_array (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .notify(notify), .notify_idx(notify_idx),
        .guest_err(guest_err), .guest_err_idx(guest_err_idx),
        .bad_idx_err(bad_idx_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model: {fire, next state}
    function automatic logic [2:0] m_trig(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b110;
            2'b10:   return 3'b011;
            2'b11:   return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [2:0] m_eoi(input logic [1:0] s);
        case (s)
            2'b10:   return 3'b000;
            2'b11:   return 3'b110;
            default: return {1'b0, s};
        endcase
    endfunction

    task automatic capture();
        g_ntf  = notify;
        g_nidx = notify_idx;
        g_gerr = guest_err;
        g_gidx = guest_err_idx;
    endtask

    task automatic do_cmd(input logic [1:0] op, input int idx, input logic [1:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_wdata = wd;
        @(negedge clk);
        capture();
        cmd_valid = 1'b0;
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        line_in[idx] = v;
        @(negedge clk);
        capture();
    endtask

    task automatic rd(input int idx, output logic [3:0] d);
        rd_idx = IW'(idx);
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [3:0] d;
        logic [2:0] e;
        logic [3:0] snap [N];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < N; i++) begin
            rd(i, d);
            chk(d[2:0] == 3'b001, "R1 reset state", d[2:0], 1);
        end
        chk(bad_idx_err == 1'b0 && notify == 1'b0, "R1 reset outputs", bad_idx_err, 0);

        // R9 kind writes: odd sources level
        for (int i = 0; i < N; i++) do_cmd(2'b11, i, 2'(i % 2));
        for (int i = 0; i < N; i++) begin
            rd(i, d);
            chk(d[3] == 1'(i % 2), "R9 kind write", d[3], i % 2);
        end

        // R2 trigger sweep, R3 EOI sweep on edge sources; R9 state write
        for (int i = 0; i < N; i += 2) begin
            for (int s = 0; s < 4; s++) begin
                do_cmd(2'b10, i, 2'(s));
                rd(i, d);
                chk(d[1:0] == 2'(s), "R9 state write", d[1:0], s);
                do_cmd(2'b00, i, 2'b00);
                e = m_trig(2'(s));
                rd(i, d);
                chk(d[1:0] == e[1:0], "R2 trigger next", d[1:0], e[1:0]);
                chk(g_ntf == e[2] && (!g_ntf || g_nidx == IW'(i)), "R2 trigger notify", g_ntf, e[2]);
                do_cmd(2'b10, i, 2'(s));
                do_cmd(2'b01, i, 2'b00);
                e = m_eoi(2'(s));
                rd(i, d);
                chk(d[1:0] == e[1:0], "R3 eoi next", d[1:0], e[1:0]);
                chk(g_ntf == e[2] && (!g_ntf || g_nidx == IW'(i)), "R3 eoi notify", g_ntf, e[2]);
            end
        end

        // R12 pulse width
        do_cmd(2'b10, 0, 2'b00);
        do_cmd(2'b00, 0, 2'b00);
        chk(g_ntf == 1'b1, "R12 pulse present", g_ntf, 1);
        @(negedge clk);
        chk(notify == 1'b0, "R12 pulse one cycle", notify, 0);

        // R2/R5 edge line
        do_cmd(2'b10, 2, 2'b00);
        set_line(2, 1'b1);
        rd(2, d);
        chk(g_ntf && g_nidx == 3'd2 && d[1:0] == 2'b10, "R2 edge line rise", d[1:0], 2);
        set_line(2, 1'b0);
        rd(2, d);
        chk(!g_ntf && d[1:0] == 2'b10, "R5 edge line fall", d[1:0], 2);
        set_line(2, 1'b1);
        rd(2, d);
        chk(!g_ntf && d[1:0] == 2'b11, "R2 edge line rise pending", d[1:0], 3);
        set_line(2, 1'b0);

        // R4 level line sweep
        for (int i = 1; i < N; i += 2) begin
            for (int s = 0; s < 4; s++) begin
                do_cmd(2'b10, i, 2'(s));
                set_line(i, 1'b1);
                rd(i, d);
                chk(g_ntf == (s == 0) && d[2] && d[1:0] == 2'(s), "R4 level rise", {g_ntf, d[2:0]}, (s == 0) * 8 + 4 + s);
                set_line(i, 1'b0);
                rd(i, d);
                chk(!g_ntf && !d[2] && d[1:0] == 2'(s), "R4 level fall", {g_ntf, d[2:0]}, s);
            end
        end

        // R6 level EOI re-evaluation
        for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 4; s++) begin
                if (a == 1) set_line(3, 1'b1);
                do_cmd(2'b10, 3, 2'(s));
                do_cmd(2'b01, 3, 2'b00);
                e = m_eoi(2'(s));
                rd(3, d);
                chk(d[1:0] == e[1:0], "R6 level eoi next", d[1:0], e[1:0]);
                chk(g_ntf == (a == 1 && e[1:0] == 2'b00), "R6 level eoi notify", g_ntf, (a == 1 && e[1:0] == 2'b00));
                if (a == 1) set_line(3, 1'b0);
            end
        end

        // R7 guest error
        do_cmd(2'b10, 1, 2'b10);
        do_cmd(2'b00, 1, 2'b00);
        chk(g_gerr && g_gidx == 3'd1, "R7 level queued", g_gerr, 1);
        do_cmd(2'b10, 1, 2'b00);
        do_cmd(2'b00, 1, 2'b00);
        chk(!g_gerr, "R7 level idle trigger", g_gerr, 0);
        do_cmd(2'b10, 0, 2'b10);
        do_cmd(2'b00, 0, 2'b00);
        chk(!g_gerr, "R7 edge queued no flag", g_gerr, 0);

        // R10 priority and ordering
        do_cmd(2'b10, 3, 2'b00);
        do_cmd(2'b10, 5, 2'b00);
        do_cmd(2'b10, 0, 2'b11);
        @(negedge clk);
        line_in[5] = 1'b1; line_in[3] = 1'b1;
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_idx = 3'd0; cmd_wdata = 2'b00;
        #1;
        chk(cmd_ready == 1'b0, "R10 ready low on change", cmd_ready, 0);
        @(negedge clk);
        chk(notify && notify_idx == 3'd3 && !cmd_ready, "R10 lowest first", notify_idx, 3);
        @(negedge clk);
        chk(notify && notify_idx == 3'd5 && cmd_ready, "R10 second line", notify_idx, 5);
        rd(0, d);
        chk(d[1:0] == 2'b11, "R10 command held", d[1:0], 3);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!notify, "R10 command no notify", notify, 0);
        rd(0, d);
        chk(d[1:0] == 2'b00, "R10 command taken", d[1:0], 0);
        set_line(3, 1'b0);
        set_line(5, 1'b0);

        // R11 out of range, R8 out-of-range read
        for (int i = 0; i < N; i++) rd(i, snap[i]);
        do_cmd(2'b00, 6, 2'b00);
        chk(!g_ntf && bad_idx_err, "R11 bad index flagged", bad_idx_err, 1);
        do_cmd(2'b10, 7, 2'b10);
        for (int i = 0; i < N; i++) begin
            rd(i, d);
            chk(d == snap[i], "R11 no state change", d, snap[i]);
        end
        do_cmd(2'b10, 0, 2'b10);
        chk(bad_idx_err, "R11 sticky", bad_idx_err, 1);
        rd(7, d);
        chk(d == 4'd0, "R8 out of range read", d, 0);
        rd(1, d);
        chk(d == 4'b1001 || d[3] == 1'b1, "R8 read format kind", d, 9);

        // R1 kind kept across reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            rd(i, d);
            chk(d == {1'(i % 2), 3'b001}, "R1 reset keeps kind", d, (i % 2) * 8 + 1);
        end
        chk(!bad_idx_err, "R1 sticky cleared", bad_idx_err, 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule